// File: doc/BRIEF.md
# Prefetch FIFO Status and Interrupt Logger

This block sits between a memory prefetch engine and the host processor that drains the fetched bytes. A start strobe loads a transfer count and makes the engine active. While active, the engine pushes bytes into a 64-entry byte FIFO. Each accepted push lowers the count of bytes the engine still has to request. When that count reaches zero, the engine drops back to inactive by itself. The host pops bytes one at a time.

The block reports the FIFO fill level, a flag that shows the fill level has reached a programmed threshold, the remaining count and the engine state. It logs two interrupt events in sticky status bits. The first is a FIFO event when the fill level crosses the threshold. The second is a terminal event when the engine finishes on its own. The host clears each status bit by writing a one to it. One interrupt line combines the logged events that are enabled.

Top module: `prefetch_fifo_status`

## Requirements
- R1: After reset the fill level is 0, the remaining count is 0, the engine is inactive, both status bits are 0, irqOut is 0 and pushReady is 0.
- R2: A start strobe loads transferCount into the remaining count. It makes the engine active at the next clock edge, unless transferCount is zero, in which case the engine stays inactive.
- R3: A push is accepted only while the engine is active and the FIFO holds fewer than 64 bytes. When the FIFO holds 64 bytes, pushReady is 0 and an offered push changes neither the fill level nor the remaining count.
- R4: Bytes come out in the order they were pushed. popData shows the oldest byte, and a pop lowers the fill level by one. A pop of an empty FIFO leaves the fill level at 0, and popData reads 0 while the FIFO is empty.
- R5: Each accepted push lowers the remaining count by one. At the clock edge where the remaining count goes from 1 to 0, the engine becomes inactive.
- R6: thresholdReached is 1 exactly when the fill level is at least the threshold input. It follows a change of the threshold input in the same cycle.
- R7: irqStatus bit 0 (the FIFO event) is set one clock edge after the fill level rises to meet the threshold, and only if the engine is active in that cycle.
- R8: Once the FIFO event has been logged, it is not raised again until two things have happened: the fill level has gone below the threshold, and bit 0 has been cleared.
- R9: irqStatus bit 1 (the terminal event) is set at the same edge where the remaining count reaches zero through a push. A start with a zero count does not set it.
- R10: While clrStrobe is high, each clrMask bit that is 1 clears the matching status bit. If an event of the same kind arrives at the same edge, the bit stays set.
- R11: irqOut is 1 exactly when some status bit and the matching irqEnable bit (bit 0 for the FIFO event, bit 1 for the terminal event) are both 1. The enables do not affect logging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Starts the engine with transferCount |
| transferCount | input | 14 | Number of bytes to prefetch |
| threshold | input | 7 | FIFO threshold in bytes |
| irqEnable | input | 2 | Interrupt enables, bit 0 FIFO event, bit 1 terminal event |
| pushValid | input | 1 | Engine offers a byte |
| pushData | input | 8 | Byte offered by the engine |
| pushReady | output | 1 | Push can be accepted |
| popStrobe | input | 1 | Host removes the oldest byte |
| popData | output | 8 | Oldest byte, 0 when empty |
| clrStrobe | input | 1 | Write-one-to-clear strobe for status |
| clrMask | input | 2 | Status bits to clear |
| fillLevel | output | 7 | Bytes held in the FIFO |
| thresholdReached | output | 1 | Fill level is at least the threshold |
| remainingCount | output | 14 | Bytes still to be requested |
| engineActive | output | 1 | Engine is started |
| irqStatus | output | 2 | Sticky event bits |
| irqOut | output | 1 | Combined interrupt |

## Verification
Fill level, remaining count, engine state and the terminal bit change at the first clock edge after a strobe. The FIFO event bit comes one edge later, because it is derived from the registered fill level. popData, thresholdReached and irqOut are combinational, so they follow their inputs within the same cycle. Each table step holds its strobes for one cycle and then idles for one more cycle before sampling at a falling edge, so every registered result has settled by the time it is checked. The same-edge collision cases place the clear strobe in exactly the cycle that ends at the edge where the event is computed.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic load;   // load remaining count
    logic push;   // write a byte, decrement remaining count
    logic pop;    // remove the oldest byte
  } pfsStrobe_t;
endpackage

// File: rtl/pfs_datapath.sv
module pfs_datapath
  import pfs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfsStrobe_t        strb,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [FILL_W-1:0] fill,
  output logic [CNT_W-1:0]  remaining,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (fill == FILL_W'(DEPTH));
  assign empty  = (fill == '0);
  assign rdData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             remaining <= '0;
    else if (strb.load)    remaining <= loadCount;
    else if (strb.push && remaining != '0) remaining <= remaining - 1'b1;
  end
endmodule

// File: rtl/pfs_control.sv
module pfs_control
  import pfs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14,
  parameter int NEVT   = 2,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [CNT_W-1:0]  transferCount,
  input  logic [FILL_W-1:0] threshold,
  input  logic [NEVT-1:0]   irqEnable,
  input  logic              pushValid,
  input  logic              popStrobe,
  input  logic              clrStrobe,
  input  logic [NEVT-1:0]   clrMask,
  input  logic [FILL_W-1:0] fill,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              full,
  input  logic              empty,
  output pfsStrobe_t        strb,
  output logic              pushReady,
  output logic              thresholdReached,
  output logic              engineActive,
  output logic [NEVT-1:0]   irqStatus,
  output logic              irqOut
);
  localparam int EVT_FIFO = 0;
  localparam int EVT_TERM = 1;

  logic            active;
  logic            condPrev;
  logic            lastByte;
  logic [NEVT-1:0] evt;

  assign pushReady        = active && !full;
  assign thresholdReached = (fill >= threshold);
  assign engineActive     = active;

  always_comb begin
    strb      = '0;
    strb.load = startStrobe;
    strb.push = pushValid && pushReady;
    strb.pop  = popStrobe && !empty;
  end

  // Engine finishes on its own when the final byte is accepted.
  assign lastByte = strb.push && (remaining == CNT_W'(1)) && !startStrobe;

  always_ff @(posedge clk) begin
    if (!rstN)            active <= 1'b0;
    else if (startStrobe) active <= (transferCount != '0);
    else if (lastByte)    active <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) condPrev <= 1'b0;
    else       condPrev <= thresholdReached;
  end

  always_comb begin
    evt           = '0;
    evt[EVT_FIFO] = active && thresholdReached && !condPrev;
    evt[EVT_TERM] = lastByte;
  end

  // Sticky, write-one-to-clear status; a new event wins over a clear.
  for (genvar g = 0; g < NEVT; g++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN)                         irqStatus[g] <= 1'b0;
      else if (evt[g])                   irqStatus[g] <= 1'b1;
      else if (clrStrobe && clrMask[g])  irqStatus[g] <= 1'b0;
    end
  end

  assign irqOut = |(irqStatus & irqEnable);
endmodule

// File: rtl/prefetch_fifo_status.sv
module prefetch_fifo_status
  import pfs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  localparam int FILL_W = $clog2(DEPTH + 1),
  localparam int NEVT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [CNT_W-1:0]  transferCount,
  input  logic [FILL_W-1:0] threshold,
  input  logic [NEVT-1:0]   irqEnable,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushReady,
  input  logic              popStrobe,
  output logic [DATA_W-1:0] popData,
  input  logic              clrStrobe,
  input  logic [NEVT-1:0]   clrMask,
  output logic [FILL_W-1:0] fillLevel,
  output logic              thresholdReached,
  output logic [CNT_W-1:0]  remainingCount,
  output logic              engineActive,
  output logic [NEVT-1:0]   irqStatus,
  output logic              irqOut
);
  pfsStrobe_t strb;
  logic       full, empty;

  pfs_control #(.DEPTH(DEPTH), .CNT_W(CNT_W), .NEVT(NEVT)) ctrl_i (
    .clk, .rstN, .startStrobe, .transferCount, .threshold, .irqEnable,
    .pushValid, .popStrobe, .clrStrobe, .clrMask,
    .fill(fillLevel), .remaining(remainingCount), .full, .empty,
    .strb, .pushReady, .thresholdReached, .engineActive, .irqStatus, .irqOut
  );

  pfs_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk, .rstN, .strb, .loadCount(transferCount), .wrData(pushData),
    .rdData(popData), .fill(fillLevel), .remaining(remainingCount),
    .full, .empty
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStrobe,
  input logic              pushValid,
  input logic              pushReady,
  input logic              popStrobe,
  input logic              clrStrobe,
  input logic [1:0]        clrMask,
  input logic [FILL_W-1:0] fillLevel,
  input logic              thresholdReached,
  input logic [CNT_W-1:0]  remainingCount,
  input logic              engineActive,
  input logic [1:0]        irqStatus
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FILL_W'(DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == FILL_W'(DEPTH)) |-> !pushReady);

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && fillLevel == '0 && !(pushValid && pushReady)) |=> (fillLevel == '0));

  assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!engineActive && !startStrobe) |=> $stable(remainingCount));

  assert_fifo_evt_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[0]) |-> ($past(engineActive) && $past(thresholdReached)));

  assert_term_evt_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[1]) |-> ($fell(engineActive) && remainingCount == '0));

  assert_term_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clrStrobe && clrMask[1] && !(pushValid && pushReady)) |=> !irqStatus[1]);
endmodule

bind prefetch_fifo_status pfs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .pushValid(pushValid),
  .pushReady(pushReady), .popStrobe(popStrobe), .clrStrobe(clrStrobe),
  .clrMask(clrMask), .fillLevel(fillLevel), .thresholdReached(thresholdReached),
  .remainingCount(remainingCount), .engineActive(engineActive),
  .irqStatus(irqStatus)
);

// File: tb/prefetch_fifo_status_tb.sv
module prefetch_fifo_status_tb_top;
  localparam int DEPTH = 64;
  localparam int NV    = 17;
  localparam logic [1:0] OP_START = 2'd0, OP_PUSH = 2'd1, OP_POP = 2'd2, OP_CLR = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 0, pushValid = 0, popStrobe = 0, clrStrobe = 0;
  logic [13:0] transferCount = '0;
  logic [6:0]  threshold = 7'd4;
  logic [1:0]  irqEnable = 2'b11, clrMask = 2'b00;
  logic [7:0]  pushData = '0;
  logic        pushReady, thresholdReached, engineActive, irqOut;
  logic [7:0]  popData;
  logic [6:0]  fillLevel;
  logic [13:0] remainingCount;
  logic [1:0]  irqStatus;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  prefetch_fifo_status dut_i (
    .clk, .rstN, .startStrobe, .transferCount, .threshold, .irqEnable,
    .pushValid, .pushData, .pushReady, .popStrobe, .popData, .clrStrobe,
    .clrMask, .fillLevel, .thresholdReached, .remainingCount, .engineActive,
    .irqStatus, .irqOut
  );

  // op, arg (count / data / expected popData / mask), exp fill, status, active, remaining
  function automatic logic [39:0] mk(input logic [1:0] op, input logic [13:0] arg,
      input logic [6:0] f, input logic [1:0] s, input logic a, input logic [13:0] r);
    return {op, arg, f, s, a, r};
  endfunction

  localparam logic [39:0] VEC [NV] = '{
    mk(OP_START, 14'd6,    7'd0, 2'b00, 1'b1, 14'd6),  // R2
    mk(OP_PUSH,  14'h10,   7'd1, 2'b00, 1'b1, 14'd5),  // R5
    mk(OP_PUSH,  14'h11,   7'd2, 2'b00, 1'b1, 14'd4),
    mk(OP_PUSH,  14'h12,   7'd3, 2'b00, 1'b1, 14'd3),
    mk(OP_PUSH,  14'h13,   7'd4, 2'b01, 1'b1, 14'd2),  // R7
    mk(OP_POP,   14'h10,   7'd3, 2'b01, 1'b1, 14'd2),  // R4
    mk(OP_PUSH,  14'h14,   7'd4, 2'b01, 1'b1, 14'd1),  // R8 rise while set
    mk(OP_CLR,   14'd1,    7'd4, 2'b00, 1'b1, 14'd1),  // R10, R8 no re-raise
    mk(OP_POP,   14'h11,   7'd3, 2'b00, 1'b1, 14'd1),
    mk(OP_PUSH,  14'h15,   7'd4, 2'b10, 1'b0, 14'd0),  // R9, R7 inactive
    mk(OP_CLR,   14'd2,    7'd4, 2'b00, 1'b0, 14'd0),  // R10
    mk(OP_POP,   14'h12,   7'd3, 2'b00, 1'b0, 14'd0),
    mk(OP_POP,   14'h13,   7'd2, 2'b00, 1'b0, 14'd0),
    mk(OP_POP,   14'h14,   7'd1, 2'b00, 1'b0, 14'd0),
    mk(OP_POP,   14'h15,   7'd0, 2'b00, 1'b0, 14'd0),
    mk(OP_POP,   14'h00,   7'd0, 2'b00, 1'b0, 14'd0),  // R4 empty
    mk(OP_PUSH,  14'h99,   7'd0, 2'b00, 1'b0, 14'd0)   // R3 inactive push
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    startStrobe = 0; pushValid = 0; popStrobe = 0; clrStrobe = 0; clrMask = 2'b00;
  endtask

  task automatic applyVec(input logic [39:0] v);
    logic [1:0]  op  = v[39:38];
    logic [13:0] arg = v[37:24];
    @(negedge clk);
    case (op)
      OP_START: begin startStrobe = 1; transferCount = arg; end
      OP_PUSH:  begin pushValid = 1; pushData = arg[7:0]; end
      OP_POP:   begin check("R4 popData", popData, arg[7:0]); popStrobe = 1; end
      default:  begin clrStrobe = 1; clrMask = arg[1:0]; end
    endcase
    @(negedge clk); idle();
    @(negedge clk);
    check("R4/R3 fill", fillLevel, v[23:17]);
    check("R7/R9/R10 status", irqStatus, v[16:15]);
    check("R2/R5 active", engineActive, v[14]);
    check("R5 remaining", remainingCount, v[13:0]);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fill", fillLevel, 0);
    check("R1 remaining", remainingCount, 0);
    check("R1 active", engineActive, 0);
    check("R1 status", irqStatus, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 pushReady", pushReady, 0);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) applyVec(VEC[i]);

    // R2 / R9: zero count start stays inactive, no terminal event
    applyVec(mk(OP_START, 14'd0, 7'd0, 2'b00, 1'b0, 14'd0));

    // R3: fill to 64
    @(negedge clk); startStrobe = 1; transferCount = 14'd70;
    @(negedge clk); idle();
    for (int i = 0; i < DEPTH; i++) begin
      pushValid = 1; pushData = 8'(i);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    check("R3 full fill", fillLevel, 64);
    check("R3 pushReady full", pushReady, 0);
    check("R5 remaining after 64", remainingCount, 6);
    check("R7 fifo evt", irqStatus, 2'b01);
    pushValid = 1; pushData = 8'hEE;
    @(negedge clk); idle();
    @(negedge clk);
    check("R3 blocked push fill", fillLevel, 64);
    check("R3 blocked push remaining", remainingCount, 6);

    // R8: clear while still above threshold, no re-raise
    clrStrobe = 1; clrMask = 2'b01;
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    check("R8 no re-raise", irqStatus, 2'b00);

    // R4: order across wrap, drain to 3
    for (int i = 0; i < 61; i++) begin
      check("R4 order", popData, 8'(i));
      popStrobe = 1;
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    check("R4 drained", fillLevel, 3);
    check("R8 still clear", irqStatus, 2'b00);

    // R10/R8: rise again with clear colliding at event edge
    pushValid = 1; pushData = 8'hA0;
    @(negedge clk); idle(); clrStrobe = 1; clrMask = 2'b01;
    @(negedge clk); idle();
    @(negedge clk);
    check("R10 set wins fifo", irqStatus, 2'b01);

    // R11
    irqEnable = 2'b10; #1;
    check("R11 masked", irqOut, 0);
    irqEnable = 2'b01; #1;
    check("R11 enabled", irqOut, 1);
    irqEnable = 2'b11;

    // R9/R10: finish 5 remaining, clear of bit1 at terminal edge
    @(negedge clk); clrStrobe = 1; clrMask = 2'b01;
    @(negedge clk); idle();
    for (int i = 0; i < 4; i++) begin
      pushValid = 1; pushData = 8'hB0;
      @(negedge clk);
    end
    pushValid = 1; clrStrobe = 1; clrMask = 2'b10;
    @(negedge clk); idle();
    @(negedge clk);
    check("R9 inactive at zero", engineActive, 0);
    check("R10 set wins term", irqStatus, 2'b10);
    check("R5 fill", fillLevel, 9);

    // R6 combinational, R7 no event while inactive
    threshold = 7'd10; #1;
    check("R6 below", thresholdReached, 0);
    @(negedge clk);
    threshold = 7'd9; #1;
    check("R6 reached", thresholdReached, 1);
    repeat (3) @(negedge clk);
    check("R7 inactive no evt", irqStatus[0], 0);

    finish();
  end
endmodule